// File: doc/BRIEF.md
# Transmit Nibble Phase-Compensation FIFO

This block is the parallel entry point on the transmit side of a serializer. On every rising edge of the write clock it takes a 4-bit word and its parity bit. It checks the pair for even parity and stores the word in a small dual-clock FIFO. The read side is timed by the reference clock. The FIFO absorbs a fixed phase offset between the two clocks, so the serializer can take one word per reference-clock cycle without caring where the write clock edges fall.

When the two clocks drift apart far enough that the writer catches up with the reader, the block drops the incoming word. It then raises a spill flag in the read domain and moves the read pointer back to the middle of the FIFO, so that operation continues with the largest possible margin. A parity bit is generated alongside every word that leaves the read side, for a downstream device to check.

Top module: `tx_nib_fifo`

## Requirements
- R1: While `arst_n` is low, `rx_valid` and `spill` are 0 and `par_ok` is 1.
- R2: Each clock domain releases reset through two flops. The first word stored is the one present at the third rising `wclk` edge after `arst_n` rises. After that, one word is stored on every rising `wclk` edge while the FIFO is not full.
- R3: The read side starts emitting only once it sees at least DEPTH/2 stored words. From then on it emits one word per rising `rclk` edge while it sees a non-empty FIFO, with `rx_valid` high. Without an overflow, words come out in write order with none lost or repeated.
- R4: A parity error exists when the XOR of the four `tx_data` bits and `tx_par` is 1. Any word whose XOR is 0 is accepted silently.
- R5: `par_ok` goes low for the two `wclk` cycles that follow the edge that sampled a bad word. A further error during that window restarts the two-cycle low period.
- R6: A word that arrives while the write side sees DEPTH words ahead of its copy of the read pointer is dropped, and `spill` then rises in the `rclk` domain.
- R7: On an overflow, the read pointer is set DEPTH/2 behind the read side's copy of the write pointer. `spill` stays high for at least one `rclk` cycle and clears once the request/acknowledge exchange between the domains is complete. Words keep coming out in write order afterwards.
- R8: `rx_par` equals the XOR of the four `rx_data` bits and changes on the same `rclk` edge as `rx_data`.
- R9: Write and read pointers cross between domains in Gray code. Each step changes at most one bit, except the single recentring jump of the read pointer.
- R10: When `rclk` runs at the same rate as `wclk` or faster, `spill` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; transmit words are sampled on its rising edge |
| rclk | input | 1 | Reference (read) clock |
| arst_n | input | 1 | Asynchronous active-low reset, released separately into each domain |
| tx_data | input | DW (4) | Transmit data word |
| tx_par | input | 1 | Even-parity bit for `tx_data` |
| par_ok | output | 1 | Low for two `wclk` cycles after a parity error |
| spill | output | 1 | Overflow indicator in the `rclk` domain |
| rx_data | output | DW (4) | Word leaving the FIFO |
| rx_par | output | 1 | Even parity of `rx_data` |
| rx_valid | output | 1 | `rx_data` holds a new word this `rclk` cycle |

## Verification
Four properties are checked on every cycle: that each Gray pointer changes by at most one bit per step, that neither side ever sees more than DEPTH words stored, that a full FIFO raises an overflow request, and that a recentring sets `spill`. Also checked on every cycle: a parity error pulls `par_ok` low on the next cycle, and `par_ok` never recovers right after an error. Only the bench scenarios can show the rest. That covers word ordering across the clock boundary, the priming threshold and the exact first stored word. It also covers the retriggered parity window, `spill` rising when the read clock is slow, `spill` clearing once the clocks agree again, and the absence of any spill at matched or faster read rates.

// File: rtl/nfifo_pkg.sv
`timescale 1ns/1ps
package nfifo_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int PAR_HOLD    = 2;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/nfifo_rst_sync.sv
`timescale 1ns/1ps
module nfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sr_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end
  assign rst_n = sr_q[STAGES-1];
endmodule

// File: rtl/nfifo_sync.sv
`timescale 1ns/1ps
module nfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end
  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/nfifo_par_chk.sv
`timescale 1ns/1ps
module nfifo_par_chk #(
  parameter int DW   = 4,
  parameter int HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data,
  input  logic          par,
  output logic          ok
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic err;

  assign err = ^{data, par};

  always_comb begin
    cnt_d = cnt_q;
    if (err)                cnt_d = CW'(HOLD);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ok = (cnt_q == '0);

  // R5: a bad word pulls the flag low on the following cycle
  a_r5_low_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !ok);
  // R5: the flag never recovers directly after an error edge
  a_r5_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> !$past(err));
endmodule

// File: rtl/nfifo_wr_ctrl.sv
`timescale 1ns/1ps
module nfifo_wr_ctrl #(
  parameter int AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW:0] rgray_s,
  input  logic        ack_s,
  output logic        wr_en,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic        ovf_req
);
  import nfifo_pkg::*;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin, fill;
  logic          full, req_q, req_d;

  assign rbin  = PW'(gray2bin(32'(rgray_s)));
  assign fill  = wbin_q - rbin;
  assign full  = (fill >= PW'(DEPTH));
  assign wr_en = rst_n & ~full;

  always_comb begin
    wbin_d  = wr_en ? wbin_q + 1'b1 : wbin_q;
    wgray_d = PW'(bin2gray(32'(wbin_d)));
    req_d   = req_q ? ~ack_s : (full & ~ack_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      req_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      req_q   <= req_d;
    end
  end

  assign waddr   = wbin_q[AW-1:0];
  assign wgray   = wgray_q;
  assign ovf_req = req_q;

  // R9: write pointer moves one Gray bit at a time
  a_r9_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));
  // R2: writer never runs more than DEPTH ahead of its view of the reader
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(DEPTH));
  // R6: a full FIFO with no pending acknowledge raises the request
  a_r6_full_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ack_s) |=> ovf_req);
endmodule

// File: rtl/nfifo_rd_ctrl.sv
`timescale 1ns/1ps
module nfifo_rd_ctrl #(
  parameter int AW    = 5,
  parameter int DW    = 4,
  parameter int PRIME = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   wgray_s,
  input  logic          req_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          spill,
  output logic [DW-1:0] rx_data,
  output logic          rx_par,
  output logic          rx_valid
);
  import nfifo_pkg::*;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, occ, rbin_q, rbin_d, rgray_q, rgray_d;
  logic          empty, realign, fire;
  logic          primed_q, primed_d, spill_q;
  logic [DW-1:0] data_q, data_d;
  logic          par_q, par_d, vld_q;

  assign wbin    = PW'(gray2bin(32'(wgray_s)));
  assign occ     = wbin - rbin_q;
  assign empty   = (occ == '0);
  assign realign = req_s & ~spill_q;
  assign fire    = primed_q & ~empty & ~realign;

  always_comb begin
    primed_d = primed_q | (occ >= PW'(PRIME));
    rbin_d   = rbin_q;
    if (realign)   rbin_d = wbin - PW'(PRIME);
    else if (fire) rbin_d = rbin_q + 1'b1;
    rgray_d  = PW'(bin2gray(32'(rbin_d)));
    data_d   = fire ? mem_q : data_q;
    par_d    = fire ? ^mem_q : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      primed_q <= 1'b0;
      spill_q  <= 1'b0;
      data_q   <= '0;
      par_q    <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      rbin_q   <= rbin_d;
      rgray_q  <= rgray_d;
      primed_q <= primed_d;
      spill_q  <= req_s;
      data_q   <= data_d;
      par_q    <= par_d;
      vld_q    <= fire;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign rgray    = rgray_q;
  assign spill    = spill_q;
  assign rx_data  = data_q;
  assign rx_par   = par_q;
  assign rx_valid = vld_q;

  // R3: reader never sees more than DEPTH words stored
  a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
  // R7: recentring is always reported on spill
  a_r7_realign_spill: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> spill);
  // R9: read pointer moves one Gray bit at a time except on the recentring jump
  a_r9_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(spill_q) |-> $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

// File: rtl/tx_nib_fifo.sv
`timescale 1ns/1ps
module tx_nib_fifo #(
  parameter int DW    = 4,
  parameter int DEPTH = 32
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          arst_n,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_par,
  output logic          par_ok,
  output logic          spill,
  output logic [DW-1:0] rx_data,
  output logic          rx_par,
  output logic          rx_valid
);
  import nfifo_pkg::*;
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic          wrst_n, rrst_n;
  logic          wr_en, ovf_req, ack_s, req_s;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;

  nfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (.clk(wclk), .arst_n(arst_n), .rst_n(wrst_n));
  nfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (.clk(rclk), .arst_n(arst_n), .rst_n(rrst_n));

  nfifo_par_chk #(.DW(DW), .HOLD(PAR_HOLD)) u_par (
    .clk(wclk), .rst_n(wrst_n), .data(tx_data), .par(tx_par), .ok(par_ok));

  nfifo_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .rgray_s(rgray_s), .ack_s(ack_s),
    .wr_en(wr_en), .waddr(waddr), .wgray(wgray), .ovf_req(ovf_req));

  always_ff @(posedge wclk) begin
    if (wr_en) mem[waddr] <= tx_data;
  end
  assign mem_q = mem[raddr];

  nfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  nfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req (
    .clk(rclk), .rst_n(rrst_n), .d(ovf_req), .q(req_s));
  nfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  nfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack (
    .clk(wclk), .rst_n(wrst_n), .d(spill), .q(ack_s));

  nfifo_rd_ctrl #(.AW(AW), .DW(DW), .PRIME(HALF)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .wgray_s(wgray_s), .req_s(req_s), .mem_q(mem_q),
    .raddr(raddr), .rgray(rgray), .spill(spill),
    .rx_data(rx_data), .rx_par(rx_par), .rx_valid(rx_valid));
endmodule

// File: tb/tx_nib_fifo_tb.sv
`timescale 1ns/1ps
module tx_nib_fifo_tb;
  localparam int DW = 4, DEPTH = 32, HALF = DEPTH / 2;

  logic wclk, rclk, arst_n, tx_par, par_ok, spill, rx_par, rx_valid;
  logic [DW-1:0] tx_data, rx_data;
  realtime rhalf = 5.0;

  int checks = 0, fails = 0;
  int wedge = 0, pcnt = 0, rx_words = 0;
  logic [DW-1:0] q[$];
  bit allow_skip = 0, no_spill = 1, spill_seen = 0, first_seen = 0, done = 0;

  tx_nib_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .tx_data(tx_data), .tx_par(tx_par),
    .par_ok(par_ok), .spill(spill), .rx_data(rx_data), .rx_par(rx_par), .rx_valid(rx_valid));

  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin rclk = 0; #3; forever #(rhalf) rclk = ~rclk; end

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural model of the write domain: stored words and parity window
  always @(posedge wclk or negedge arst_n) begin
    if (!arst_n) begin
      wedge = 0; pcnt = 0; q.delete();
    end else begin
      wedge++;
      if (wedge >= 3) begin
        if (^{tx_data, tx_par}) pcnt = 2;
        else if (pcnt > 0) pcnt--;
        q.push_back(tx_data);
      end
    end
  end

  // R4 / R5: parity flag compared every write cycle
  always @(negedge wclk) begin
    if (arst_n && !done) chk(par_ok == (pcnt == 0), "R4/R5", "par_ok", par_ok, pcnt == 0);
  end

  // Read side: ordering, parity generation, spill
  always @(negedge rclk) begin
    if (arst_n && !done) begin
      if (spill) spill_seen = 1;
      if (no_spill) chk(!spill, "R10", "spill at matched/fast rate", spill, 0);
      if (rx_valid) begin
        rx_words++;
        chk(rx_par == ^rx_data, "R8", "rx_par", rx_par, ^rx_data);
        if (!first_seen) begin
          first_seen = 1;
          chk(q.size() >= HALF, "R3", "words stored before first output", q.size(), HALF);
        end
        if (q.size() == 0) chk(0, "R3", "output with nothing written", rx_data, -1);
        else if (q[0] == rx_data) begin
          chk(1, "R2/R3", "order", rx_data, q[0]);
          void'(q.pop_front());
        end else if (allow_skip) begin
          while (q.size() > 0 && q[0] != rx_data) void'(q.pop_front());
          chk(q.size() > 0, "R7", "word after realign in write order", rx_data, -1);
          if (q.size() > 0) void'(q.pop_front());
        end else begin
          chk(0, "R2/R3", "order", rx_data, q[0]);
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge wclk);
    arst_n = 0;
    repeat (3) @(negedge wclk);
    chk(rx_valid == 0, "R1", "rx_valid in reset", rx_valid, 0);
    chk(spill == 0, "R1", "spill in reset", spill, 0);
    chk(par_ok == 1, "R1", "par_ok in reset", par_ok, 1);
    first_seen = 0;
    @(negedge wclk);
    arst_n = 1;
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d;
      bit bad;
      d = (mode == 0) ? DW'(i) : DW'(i * 7 + 3);
      bad = (mode == 0) && (i == 50 || i == 80 || i == 81 || i == 120 || i == 122);
      if (mode == 1) bad = (i == 40 || i == 41 || i == 42);
      tx_data = d;
      tx_par  = (^d) ^ bad;
      @(negedge wclk);
    end
  endtask

  initial begin
    arst_n = 1; tx_data = '0; tx_par = 1'b0;
    do_reset();
    // Matched rate with a phase offset: strict order, no spill
    run(300, 0);
    chk(q.size() <= DEPTH, "R3", "backlog at matched rate", q.size(), DEPTH);
    // Slow read clock: overflow expected
    no_spill = 0; allow_skip = 1; spill_seen = 0;
    rhalf = 6.5;
    run(400, 0);
    chk(spill_seen, "R6", "spill raised on overflow", spill_seen, 1);
    // Fast read clock: realignment finishes and spill clears
    rhalf = 4.0;
    rx_words = 0;
    run(200, 0);
    @(negedge rclk);
    chk(spill == 0, "R7", "spill cleared after realign", spill, 0);
    chk(rx_words > 100, "R7", "output continues after realign", rx_words, 100);
    // Fresh start with fast read clock: strict order, other pattern
    allow_skip = 0; no_spill = 1;
    do_reset();
    rx_words = 0;
    run(300, 1);
    chk(q.size() <= 8, "R3", "backlog drained at fast rate", q.size(), 8);
    chk(rx_words >= 280, "R3", "words read at fast rate", rx_words, 280);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule